// File: doc/BRIEF.md
# Audio Link Input Frame Receiver

This block sits in a digital audio controller and takes in the serial return stream from an audio codec. The controller drives its own frame-start pulse. The receiver detects the rising edge of that pulse on a falling bit-clock edge and then captures one bit per falling edge. It splits the frame into a 16-bit tag followed by twelve 20-bit slots.

The tag tells the receiver which fields can be trusted. A register read completes when the codec is ready and both the status-address and status-data marks are set. It produces a one-cycle strobe with the echoed register index and the 16-bit data. Left and right PCM samples are taken from slots 3 and 4, each with its own strobe. The codec's active-low slot requests in slot 1 become active-high send permissions. The outbound frame builder uses these permissions for the next frame it sends.

All logic is clocked on the falling edge of the bit clock.

Top module: `alink_rx`

## Requirements
- R1: A 0-to-1 change of `sync` seen at a falling edge marks a frame start, and the next falling edge captures the first bit of the frame. A new rising edge of `sync` in the middle of a frame restarts the bit and slot count.
- R2: The frame is a 16-bit tag followed by 20-bit slots, each sent MSB first. Slot n (n ≥ 1) occupies frame bits 16+20(n-1) to 35+20(n-1), where bit 0 is the first bit received.
- R3: `codec_ready` takes the value of tag bit 15, the first bit of the frame. It is updated on the falling edge that captures the last tag bit and holds until the next frame's tag.
- R4: When tag bits 15, 14 and 13 are all 1, `rd_done` is high for exactly one cycle. That cycle follows the capture of the last bit of slot 2, which is frame bit 55. With the strobe, `rd_index` shows slot 1 bits 18:12 and `rd_data` shows slot 2 bits 19:4.
- R5: When tag bit 15 and tag bit 12 are 1, `pcm_l` takes slot 3 bits 19:(20-SAMPLE_W), and `pcm_l_stb` pulses for one cycle after frame bit 75. Tag bit 11 does the same for slot 4 into `pcm_r` and `pcm_r_stb`, with the pulse after frame bit 95.
- R6: A field whose tag bit is 0, or any field in a frame whose tag bit 15 is 0, produces no strobe and leaves its output registers unchanged.
- R7: In a frame with tag bit 15 set, `send_perm` is updated after the last bit of slot 1. Each flag is the inverse of a slot 1 bit, in this order: bit 0 from bit 11 (out slot 3), bit 1 from bit 10 (out slot 4), bit 2 from bit 8 (out slot 6), bit 3 from bit 7 (out slot 7), bit 4 from bit 6 (out slot 8), and bit 5 from bit 5 (out slot 9).
- R8: In a frame with tag bit 15 clear, `send_perm` is cleared to all zeros at the end of slot 1.
- R9: `send_perm` changes only at the end of slot 1 and holds between those points.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; logic runs on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Controller's frame-start pulse |
| sdin | input | 1 | Serial data from the codec |
| codec_ready | output | 1 | Tag bit 15 of the latest frame |
| rd_done | output | 1 | One-cycle register read completion strobe |
| rd_index | output | 7 | Echoed register index |
| rd_data | output | 16 | Returned register data |
| pcm_l | output | SAMPLE_W | Left PCM sample |
| pcm_l_stb | output | 1 | Left sample strobe |
| pcm_r | output | SAMPLE_W | Right PCM sample |
| pcm_r_stb | output | 1 | Right sample strobe |
| send_perm | output | 6 | Send permissions for outbound slots 3,4,6,7,8,9 |

## Verification
The bound checker watches every cycle for the following:
- no strobe fires while the codec is marked not ready;
- the read, left and right strobes never coincide and last one cycle;
- the held output registers and `send_perm` move only at their own update points;
- a not-ready frame clears the permissions.

Some behaviour can only be shown by the bench's frames:
- the slot boundaries, bit order and field positions;
- the exact cycle each strobe appears;
- the inversion map for the permissions;
- a restart in the middle of a frame.

// File: rtl/alink_pkg.sv
package alink_pkg;

  localparam int REG_IDX_W  = 7;
  localparam int REG_DATA_W = 16;
  localparam int PERM_W     = 6;

  typedef struct packed {
    logic ready;
    logic addr_ok;
    logic data_ok;
    logic left_ok;
    logic right_ok;
  } tag_flags_t;

  // Length in bits of a slot: the tag is shorter than the data slots.
  function automatic int slot_len(input int slot, input int tag_w, input int slot_w);
    return (slot == 0) ? tag_w : slot_w;
  endfunction

  // The leading five bits of the tag carry ready and per-slot validity.
  function automatic tag_flags_t decode_tag(input logic [15:0] tag);
    tag_flags_t f;
    f.ready    = tag[15];
    f.addr_ok  = tag[14];
    f.data_ok  = tag[13];
    f.left_ok  = tag[12];
    f.right_ok = tag[11];
    return f;
  endfunction

  // Active-low requests become active-high permissions.
  // Output order: slots 3,4,6,7,8,9.
  function automatic logic [PERM_W-1:0] perm_from_req(input logic [19:0] s1);
    return ~{s1[5], s1[6], s1[7], s1[8], s1[10], s1[11]};
  endfunction

endpackage

// File: rtl/alink_frame_timer.sv
module alink_frame_timer #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 13,
  parameter int BIT_CW    = $clog2(SLOT_W),
  parameter int SLOT_CW   = $clog2(NUM_SLOTS)
) (
  input  logic               bit_clk,
  input  logic               rst_n,
  input  logic               sync,
  output logic               frame_go,
  output logic               shift_en,
  output logic               slot_last,
  output logic [SLOT_CW-1:0] slot_idx
);
  import alink_pkg::*;

  logic              sync_q;
  logic              active;
  logic [BIT_CW-1:0] bit_q;

  assign frame_go  = sync & ~sync_q;
  assign shift_en  = active & ~frame_go;
  assign slot_last = shift_en &
                     (int'(bit_q) == slot_len(int'(slot_idx), TAG_W, SLOT_W) - 1);

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      active   <= 1'b0;
      bit_q    <= '0;
      slot_idx <= '0;
    end else begin
      sync_q <= sync;
      if (frame_go) begin
        active   <= 1'b1;
        bit_q    <= '0;
        slot_idx <= '0;
      end else if (active) begin
        if (slot_last) begin
          bit_q <= '0;
          if (slot_idx == SLOT_CW'(NUM_SLOTS - 1)) active <= 1'b0;
          else slot_idx <= slot_idx + 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/alink_shift.sv
module alink_shift #(
  parameter int SLOT_W = 20
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sdin,
  output logic [SLOT_W-1:0] word
);
  logic [SLOT_W-2:0] sh_q;

  // The word includes the bit being captured now.
  assign word = {sh_q, sdin};

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= word[SLOT_W-2:0];
  end
endmodule

// File: rtl/alink_slot_decode.sv
module alink_slot_decode #(
  parameter int TAG_W    = 16,
  parameter int SLOT_W   = 20,
  parameter int SAMPLE_W = 16
) (
  input  logic                                bit_clk,
  input  logic                                rst_n,
  input  logic [4:0]                          slot_hit,
  input  logic [SLOT_W-1:0]                   word,
  output logic                                codec_ready,
  output logic                                rd_done,
  output logic [alink_pkg::REG_IDX_W-1:0]     rd_index,
  output logic [alink_pkg::REG_DATA_W-1:0]    rd_data,
  output logic [SAMPLE_W-1:0]                 pcm_l,
  output logic                                pcm_l_stb,
  output logic [SAMPLE_W-1:0]                 pcm_r,
  output logic                                pcm_r_stb,
  output logic [alink_pkg::PERM_W-1:0]        send_perm
);
  import alink_pkg::*;

  tag_flags_t           flags_q;
  logic [REG_IDX_W-1:0] pend_idx;
  logic                 pend_ok;

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q     <= '0;
      codec_ready <= 1'b0;
      pend_idx    <= '0;
      pend_ok     <= 1'b0;
      rd_done     <= 1'b0;
      rd_index    <= '0;
      rd_data     <= '0;
      pcm_l       <= '0;
      pcm_l_stb   <= 1'b0;
      pcm_r       <= '0;
      pcm_r_stb   <= 1'b0;
      send_perm   <= '0;
    end else begin
      rd_done   <= 1'b0;
      pcm_l_stb <= 1'b0;
      pcm_r_stb <= 1'b0;
      if (slot_hit[0]) begin
        flags_q     <= decode_tag(word[TAG_W-1:TAG_W-16]);
        codec_ready <= word[TAG_W-1];
      end
      if (slot_hit[1]) begin
        pend_ok   <= flags_q.ready & flags_q.addr_ok;
        pend_idx  <= word[SLOT_W-2 -: REG_IDX_W];
        send_perm <= flags_q.ready ? perm_from_req(word[19:0]) : '0;
      end
      if (slot_hit[2] && pend_ok && flags_q.data_ok) begin
        rd_done  <= 1'b1;
        rd_index <= pend_idx;
        rd_data  <= word[SLOT_W-1 -: REG_DATA_W];
      end
      if (slot_hit[3] && flags_q.ready && flags_q.left_ok) begin
        pcm_l     <= word[SLOT_W-1 -: SAMPLE_W];
        pcm_l_stb <= 1'b1;
      end
      if (slot_hit[4] && flags_q.ready && flags_q.right_ok) begin
        pcm_r     <= word[SLOT_W-1 -: SAMPLE_W];
        pcm_r_stb <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/alink_rx.sv
module alink_rx #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 13,
  parameter int SAMPLE_W  = 16
) (
  input  logic                bit_clk,
  input  logic                rst_n,
  input  logic                sync,
  input  logic                sdin,
  output logic                codec_ready,
  output logic                rd_done,
  output logic [6:0]          rd_index,
  output logic [15:0]         rd_data,
  output logic [SAMPLE_W-1:0] pcm_l,
  output logic                pcm_l_stb,
  output logic [SAMPLE_W-1:0] pcm_r,
  output logic                pcm_r_stb,
  output logic [5:0]          send_perm
);
  localparam int BIT_CW  = $clog2(SLOT_W);
  localparam int SLOT_CW = $clog2(NUM_SLOTS);
  localparam int DEC_SLOTS = 5;

  logic               frame_go;
  logic               shift_en;
  logic               slot_last;
  logic [SLOT_CW-1:0] slot_idx;
  logic [SLOT_W-1:0]  word;
  logic [DEC_SLOTS-1:0] slot_hit;
  logic               slot1_end;

  alink_frame_timer #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
    .BIT_CW(BIT_CW), .SLOT_CW(SLOT_CW)
  ) u_timer (
    .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync),
    .frame_go(frame_go), .shift_en(shift_en),
    .slot_last(slot_last), .slot_idx(slot_idx)
  );

  alink_shift #(.SLOT_W(SLOT_W)) u_shift (
    .bit_clk(bit_clk), .rst_n(rst_n), .shift_en(shift_en),
    .sdin(sdin), .word(word)
  );

  for (genvar s = 0; s < DEC_SLOTS; s++) begin : g_hit
    assign slot_hit[s] = slot_last & (slot_idx == SLOT_CW'(s));
  end

  assign slot1_end = slot_hit[1];

  alink_slot_decode #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)
  ) u_dec (
    .bit_clk(bit_clk), .rst_n(rst_n), .slot_hit(slot_hit), .word(word),
    .codec_ready(codec_ready), .rd_done(rd_done), .rd_index(rd_index),
    .rd_data(rd_data), .pcm_l(pcm_l), .pcm_l_stb(pcm_l_stb),
    .pcm_r(pcm_r), .pcm_r_stb(pcm_r_stb), .send_perm(send_perm)
  );
endmodule

// File: rtl/alink_rx_chk.sv
module alink_rx_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                bit_clk,
  input logic                rst_n,
  input logic                codec_ready,
  input logic                rd_done,
  input logic [6:0]          rd_index,
  input logic [15:0]         rd_data,
  input logic [SAMPLE_W-1:0] pcm_l,
  input logic                pcm_l_stb,
  input logic [SAMPLE_W-1:0] pcm_r,
  input logic                pcm_r_stb,
  input logic [5:0]          send_perm,
  input logic                slot1_end
);
  AST_STB_NEEDS_READY: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (rd_done | pcm_l_stb | pcm_r_stb) |-> codec_ready); // R6
  AST_STB_EXCLUSIVE: assert property (@(negedge bit_clk) disable iff (!rst_n)
    $onehot0({rd_done, pcm_l_stb, pcm_r_stb})); // R2
  AST_RD_ONE_CYCLE: assert property (@(negedge bit_clk) disable iff (!rst_n)
    rd_done |=> !rd_done); // R4
  AST_RD_HOLD: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !rd_done |-> ($stable(rd_index) && $stable(rd_data))); // R6
  AST_PCM_L_HOLD: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !pcm_l_stb |-> $stable(pcm_l)); // R5
  AST_PCM_R_HOLD: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !pcm_r_stb |-> $stable(pcm_r)); // R5
  AST_PERM_CLEAR: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (slot1_end && !codec_ready) |=> (send_perm == 6'd0)); // R8
  AST_PERM_HOLD: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !slot1_end |=> $stable(send_perm)); // R9
endmodule

bind alink_rx alink_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .codec_ready(codec_ready),
  .rd_done(rd_done), .rd_index(rd_index), .rd_data(rd_data),
  .pcm_l(pcm_l), .pcm_l_stb(pcm_l_stb), .pcm_r(pcm_r),
  .pcm_r_stb(pcm_r_stb), .send_perm(send_perm), .slot1_end(slot1_end)
);

// File: tb/alink_rx_bench.sv
module alink_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;

  logic bit_clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic sdin = 1'b0;
  logic          codec_ready, rd_done, pcm_l_stb, pcm_r_stb;
  logic [6:0]    rd_index;
  logic [15:0]   rd_data;
  logic [SW-1:0] pcm_l, pcm_r;
  logic [5:0]    send_perm;

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  alink_rx #(.SAMPLE_W(SW)) u_alink_rx (
    .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .sdin(sdin),
    .codec_ready(codec_ready), .rd_done(rd_done), .rd_index(rd_index),
    .rd_data(rd_data), .pcm_l(pcm_l), .pcm_l_stb(pcm_l_stb),
    .pcm_r(pcm_r), .pcm_r_stb(pcm_r_stb), .send_perm(send_perm)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, f0 = 0;
  int n_rd = 0, n_l = 0, n_r = 0;
  int rd_cyc = 0, l_cyc = 0, r_cyc = 0;

  // Monitor on rising edges, away from the falling edge the design uses.
  always @(posedge bit_clk) begin
    cyc <= cyc + 1;
    if (rd_done)   begin n_rd <= n_rd + 1; rd_cyc <= cyc; end
    if (pcm_l_stb) begin n_l  <= n_l + 1;  l_cyc  <= cyc; end
    if (pcm_r_stb) begin n_r  <= n_r + 1;  r_cyc  <= cyc; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected state of the outputs.
  logic          e_ready = 0;
  logic [6:0]    e_idx = 0;
  logic [15:0]   e_dat = 0;
  logic [SW-1:0] e_l = 0, e_r = 0;
  logic [5:0]    e_perm = 0;
  int            e_nrd, e_nl, e_nr;

  function automatic logic [5:0] bench_perm(input logic [19:0] s1);
    int pos [6] = '{11, 10, 8, 7, 6, 5};
    logic [5:0] p;
    for (int k = 0; k < 6; k++) p[k] = (s1[pos[k]] == 1'b0);
    return p;
  endfunction

  function automatic logic [255:0] mk(input logic [15:0] tag,
      input logic [19:0] s1, s2, s3, s4, input logic [159:0] rest);
    return {tag, s1, s2, s3, s4, rest};
  endfunction

  task automatic model(input logic [15:0] tag, input logic [19:0] s1, s2, s3, s4);
    e_nrd = 0; e_nl = 0; e_nr = 0;
    e_ready = tag[15];
    e_perm  = tag[15] ? bench_perm(s1) : 6'd0;
    if (tag[15] && tag[14] && tag[13]) begin
      e_idx = s1[18:12]; e_dat = s2[19:4]; e_nrd = 1;
    end
    if (tag[15] && tag[12]) begin e_l = s3[19:4]; e_nl = 1; end
    if (tag[15] && tag[11]) begin e_r = s4[19:4]; e_nr = 1; end
  endtask

  // Drive nbits of a frame, MSB of fr first, one bit per rising edge.
  task automatic drive(input logic [255:0] fr, input int nbits);
    @(posedge bit_clk); #1;
    sync = 1'b1; sdin = 1'b0; f0 = cyc;
    for (int i = 0; i < nbits; i++) begin
      @(posedge bit_clk); #1;
      sdin = fr[255-i];
      if (i == 15) sync = 1'b0;
    end
    if (nbits <= 15) sync = 1'b0;
  endtask

  task automatic run_frame(input logic [15:0] tag, input logic [19:0] s1, s2, s3, s4,
                           input string req);
    int b_rd, b_l, b_r;
    logic [159:0] rest;
    rest = {$urandom, $urandom, $urandom, $urandom, $urandom};
    b_rd = n_rd; b_l = n_l; b_r = n_r;
    model(tag, s1, s2, s3, s4);
    drive(mk(tag, s1, s2, s3, s4, rest), 256);
    @(posedge bit_clk); #1;
    check({req, " R3 ready"},  {31'd0, codec_ready}, {31'd0, e_ready});
    check({req, " R7 perm"},   {26'd0, send_perm}, {26'd0, e_perm});
    check({req, " R4 index"},  {25'd0, rd_index}, {25'd0, e_idx});
    check({req, " R4 data"},   {16'd0, rd_data}, {16'd0, e_dat});
    check({req, " R5 left"},   {16'd0, pcm_l}, {16'd0, e_l});
    check({req, " R5 right"},  {16'd0, pcm_r}, {16'd0, e_r});
    check({req, " R6 rd count"}, n_rd - b_rd, e_nrd);
    check({req, " R6 l count"},  n_l - b_l, e_nl);
    check({req, " R6 r count"},  n_r - b_r, e_nr);
  endtask

  initial begin : main
    logic [15:0] tg;
    logic [19:0] a, b, c, d;
    void'($urandom(32'd4242));
    repeat (4) @(posedge bit_clk);
    #1 rst_n = 1'b1;
    @(posedge bit_clk); #1;
    // R10: reset state
    check("R10 ready", {31'd0, codec_ready}, 0);
    check("R10 strobes", {29'd0, rd_done, pcm_l_stb, pcm_r_stb}, 0);
    check("R10 perm", {26'd0, send_perm}, 0);
    check("R10 data", {16'd0, rd_data}, 0);

    // Directed: all valid, with timing of each strobe (R2, R4, R5, R7)
    a = {1'b0, 7'h26, 12'h4A0};
    run_frame(16'hF800, a, 20'hA5C3_7, 20'h12345, 20'hFEDCB, "R7 full");
    check("R4 rd_done cycle", rd_cyc - f0, 56);
    check("R5 left cycle", l_cyc - f0, 76);
    check("R5 right cycle", r_cyc - f0, 96);
    check("R7 perm map", {26'd0, send_perm}, 32'h15);

    // Not ready: fields marked valid are still ignored (R6, R8)
    run_frame(16'h7800, 20'h3FFFF, 20'h11111, 20'h22222, 20'h33333, "R8 notready");
    // Ready, data mark without address mark: no read (R6)
    run_frame(16'hA000, 20'h55000, 20'h99999, 20'h0, 20'h0, "R6 dataonly");
    // Ready, address and right only (R6, R5)
    run_frame(16'hC800, 20'h0F000, 20'h77777, 20'h44444, 20'h6789A, "R5 rightonly");

    // Restart mid-frame (R1): partial frame then a full one
    tg = 16'hF800;
    drive(mk(16'hFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 160'd0), 30);
    run_frame(tg, {1'b0, 7'h11, 12'h000}, 20'hBEEF0, 20'hCAFE0, 20'hD00D0, "R1 restart");
    check("R1 restart rd cycle", rd_cyc - f0, 56);

    // Constrained random frames (R2..R9)
    for (int n = 0; n < 40; n++) begin
      tg = {($urandom_range(3) != 0), 4'($urandom), 11'($urandom)};
      a = 20'($urandom); b = 20'($urandom); c = 20'($urandom); d = 20'($urandom);
      run_frame(tg, a, b, c, d, "R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge bit_clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule